// File: doc/BRIEF.md
# Serial Polynomial Multiplier Encoder

This block turns a serial message into a cyclic code word by multiplying the message polynomial by a fixed generator polynomial over GF(2). The output is the full product, so it is a non-separable code. The message bits are not copied into the output and cannot be recovered by dropping a trailing check field. Message bits enter one per clock, qualified by a valid strobe. The lowest coefficient arrives first. Code coefficients leave one per clock, also lowest first, one cycle after the clock that produced them.

Each delay stage of the multiplier is a flip-flop, which stands for one multiplication by x. Each sum is an XOR over the stages that the nonzero generator coefficients select. Once the configured number of message bits has been accepted, the block runs one flush cycle per degree of the generator with zero injected internally, so that the high-order product terms come out. A one-cycle done flag marks the last coefficient. A synchronous clear zeroes every stage and readies the block for the next message. The generator is a parameter whose lowest and highest coefficients must both be 1.

Top module: `polyMulEnc`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `codeValid` and `done` are 0.
- R2: When a message bit is accepted, the next cycle shows on `codeOut` the XOR of that bit with the earlier accepted bits (or flush zeros) delayed by j cycles, for every j from 1 to the degree where generator bit j is 1. `codeValid` is 1 in that cycle.
- R3: A cycle with `dataValid` low while the block is accepting message bits neither shifts the stages nor yields a code bit (`codeValid` is 0 in the following cycle).
- R4: After MSG_BITS accepted bits, the block runs exactly GEN_DEG flush cycles with a zero input and yields one code bit per cycle, whatever `dataValid` and `dataIn` do. A message yields exactly MSG_BITS+GEN_DEG code bits.
- R5: `done` is high for exactly one cycle, and that cycle is the one that carries the last code coefficient (`codeValid` also high).
- R6: After `done`, the block ignores `dataValid` and yields no code bits until `clear` is applied.
- R7: `clear` zeroes all stages and the done flag from the next cycle on, even in the middle of a message, so an aborted message does not alter the next code word.
- R8: With generator 1+x+x^3 (parameter value 4'b1011, bit i is the coefficient of x^i) and message bits 1,1,0,1 (lowest first), the code bits are 1,0,1,0,0,0,1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of all stages and control state |
| dataIn | input | 1 | Message bit, lowest coefficient first |
| dataValid | input | 1 | Qualifies `dataIn` while a message is being accepted |
| codeOut | output | 1 | Code coefficient, lowest first |
| codeValid | output | 1 | `codeOut` carries a coefficient this cycle |
| done | output | 1 | One-cycle flag with the last coefficient |

## Verification
A stage left with a wrong value spoils the code bit in the very next cycle in which its generator tap is set. That error then propagates to one later coefficient per remaining tap, so every wrong stage shows up within GEN_DEG code bits. A flush or message counter that is off by one changes the number of code bits and moves the done flag. Both can be seen as soon as the message ends. The bench sweeps every 4-bit message, with several stall patterns and with junk driven during flush and hold, and compares each code word against a carry-less product computed in the bench.

// File: rtl/polyMulEnc_pkg.sv
package polyMulEnc_pkg;

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_FLUSH = 2'd1,
    ST_HOLD  = 2'd2
  } encState_t;

  typedef struct packed {
    logic clearRegs;
    logic shiftEn;
    logic injectZero;
  } encStrobe_t;

endpackage

// File: rtl/polyMulEnc_ctrl.sv
module polyMulEnc_ctrl
  import polyMulEnc_pkg::*;
#(
  parameter int MSG_BITS = 4,
  parameter int GEN_DEG  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       dataValid,
  output encStrobe_t strb,
  output logic       doneQ
);

  localparam int MAX_CNT = (MSG_BITS > GEN_DEG) ? MSG_BITS : GEN_DEG;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] LAST_MSG   = CNT_W'(MSG_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_FLUSH = CNT_W'(GEN_DEG - 1);

  encState_t       state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic            doneNxt;

  always_comb begin
    strb.clearRegs  = clear;
    strb.shiftEn    = 1'b0;
    strb.injectZero = 1'b0;
    stateNxt        = state;
    cntNxt          = cnt;
    doneNxt         = 1'b0;
    if (clear) begin
      stateNxt = ST_LOAD;
      cntNxt   = '0;
    end else begin
      unique case (state)
        ST_LOAD: begin
          if (dataValid) begin
            strb.shiftEn = 1'b1;
            if (cnt == LAST_MSG) begin
              stateNxt = ST_FLUSH;
              cntNxt   = '0;
            end else begin
              cntNxt = cnt + 1'b1;
            end
          end
        end
        ST_FLUSH: begin
          strb.shiftEn    = 1'b1;
          strb.injectZero = 1'b1;
          if (cnt == LAST_FLUSH) begin
            stateNxt = ST_HOLD;
            cntNxt   = '0;
            doneNxt  = 1'b1;
          end else begin
            cntNxt = cnt + 1'b1;
          end
        end
        default: begin
          stateNxt = ST_HOLD;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_LOAD;
      cnt   <= '0;
      doneQ <= 1'b0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      doneQ <= doneNxt;
    end
  end

endmodule

// File: rtl/polyMulEnc_dp.sv
module polyMulEnc_dp
  import polyMulEnc_pkg::*;
#(
  parameter int                 GEN_DEG  = 3,
  parameter logic [GEN_DEG:0]   GEN_POLY = 4'b1011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  encStrobe_t strb,
  input  logic       dataIn,
  output logic       codeOut,
  output logic       codeValid
);

  // hist[j] holds the input applied j+1 shifts ago
  logic [GEN_DEG-1:0] hist, histNxt;
  logic [GEN_DEG-1:0] tapTerm;
  logic               inBit;
  logic               sumBit;

  assign inBit = strb.injectZero ? 1'b0 : dataIn;

  for (genvar j = 0; j < GEN_DEG; j++) begin : g_tap
    assign tapTerm[j] = GEN_POLY[j+1] & hist[j];
  end

  assign sumBit = inBit ^ (^tapTerm);

  if (GEN_DEG == 1) begin : g_hist1
    assign histNxt = inBit;
  end else begin : g_histN
    assign histNxt = {hist[GEN_DEG-2:0], inBit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist      <= '0;
      codeOut   <= 1'b0;
      codeValid <= 1'b0;
    end else if (strb.clearRegs) begin
      hist      <= '0;
      codeOut   <= 1'b0;
      codeValid <= 1'b0;
    end else begin
      codeValid <= strb.shiftEn;
      if (strb.shiftEn) begin
        hist    <= histNxt;
        codeOut <= sumBit;
      end
    end
  end

endmodule

// File: rtl/polyMulEnc.sv
module polyMulEnc
  import polyMulEnc_pkg::*;
#(
  parameter int               MSG_BITS = 4,
  parameter int               GEN_DEG  = 3,
  parameter logic [GEN_DEG:0] GEN_POLY = 4'b1011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic dataIn,
  input  logic dataValid,
  output logic codeOut,
  output logic codeValid,
  output logic done
);

  encStrobe_t strb;

  polyMulEnc_ctrl #(
    .MSG_BITS(MSG_BITS),
    .GEN_DEG (GEN_DEG)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .dataValid(dataValid),
    .strb     (strb),
    .doneQ    (done)
  );

  polyMulEnc_dp #(
    .GEN_DEG (GEN_DEG),
    .GEN_POLY(GEN_POLY)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .dataIn   (dataIn),
    .codeOut  (codeOut),
    .codeValid(codeValid)
  );

endmodule

// File: rtl/polyMulEnc_chk.sv
module polyMulEnc_chk
  import polyMulEnc_pkg::*;
#(
  parameter int MSG_BITS = 4,
  parameter int GEN_DEG  = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clear,
  input logic       codeValid,
  input logic       done,
  input encStrobe_t strb
);

  localparam int CODE_LEN = MSG_BITS + GEN_DEG;
  localparam int CW       = $clog2(CODE_LEN + 2);

  logic [CW-1:0] codeCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           codeCnt <= '0;
    else if (clear)                       codeCnt <= '0;
    else if (codeValid && codeCnt != CW'(CODE_LEN + 1)) codeCnt <= codeCnt + 1'b1;
  end

  // R1 / R7: clear silences the outputs in the next cycle
  a_r7_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!codeValid && !done));

  // R3: no shift means no code bit next cycle
  a_r3_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.shiftEn) |=> !codeValid);

  // R2: an accepted shift yields a code bit next cycle
  a_r2_bit_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.shiftEn && !strb.clearRegs) |=> codeValid);

  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: done rides on the last coefficient
  a_r5_done_with_code: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> codeValid);

  // R4: done arrives after exactly CODE_LEN-1 earlier code bits
  a_r4_code_len: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (codeCnt == CW'(CODE_LEN - 1)));

  // R6: nothing more after a full code word
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (codeCnt >= CW'(CODE_LEN)) |-> !codeValid);

endmodule

bind polyMulEnc polyMulEnc_chk #(
  .MSG_BITS(MSG_BITS),
  .GEN_DEG (GEN_DEG)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clear    (clear),
  .codeValid(codeValid),
  .done     (done),
  .strb     (strb)
);

// File: tb/polyMulEnc_bench.sv
module polyMulEnc_bench;

  localparam int         K    = 4;
  localparam int         DEG  = 3;
  localparam logic [3:0] GEN  = 4'b1011;
  localparam int         NLEN = K + DEG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic dataIn = 1'b0;
  logic dataValid = 1'b0;
  logic codeOut, codeValid, done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  polyMulEnc #(.MSG_BITS(K), .GEN_DEG(DEG), .GEN_POLY(GEN)) u_polyMulEnc (
    .clk(clk), .rst_n(rst_n), .clear(clear), .dataIn(dataIn),
    .dataValid(dataValid), .codeOut(codeOut), .codeValid(codeValid), .done(done)
  );

  // capture of outputs, sampled on the falling edge
  logic [15:0] capVal = '0;
  int capCnt = 0;
  int doneCnt = 0;
  int doneAt = -1;

  always @(negedge clk) begin
    if (clear) begin
      capVal = '0; capCnt = 0; doneCnt = 0; doneAt = -1;
    end else if (rst_n) begin
      if (codeValid) begin
        if (capCnt < 16) capVal[capCnt] = codeOut;
        capCnt = capCnt + 1;
      end
      if (done) begin
        doneCnt = doneCnt + 1;
        doneAt = capCnt;
      end
    end
  end

  function automatic logic [15:0] clmul(input logic [3:0] m);
    logic [15:0] r = '0;
    for (int i = 0; i < K; i++)
      if (m[i]) r = r ^ (16'(GEN) << i);
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic doClear();
    clear = 1'b1; dataValid = 1'b0; tick(); clear = 1'b0;
  endtask

  // gapSel picks a stall pattern before each bit; junk is driven during flush and hold
  task automatic sendMsg(input logic [3:0] m, input int gapSel);
    for (int i = 0; i < K; i++) begin
      if (((gapSel >> i) & 1) == 1) begin
        dataValid = 1'b0; dataIn = 1'b1; tick();
      end
      dataValid = 1'b1; dataIn = m[i]; tick();
    end
    for (int j = 0; j < DEG + 4; j++) begin
      dataValid = 1'b1; dataIn = j[0]; tick();
    end
    dataValid = 1'b0; tick(); tick();
  endtask

  initial begin
    // R1: reset state
    tick(); tick();
    @(negedge clk);
    check("R1 codeValid in reset", int'(codeValid), 0);
    check("R1 done in reset", int'(done), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 codeValid after reset", int'(codeValid), 0);
    check("R1 done after reset", int'(done), 0);

    // R8: worked example
    doClear();
    sendMsg(4'b1011, 0);
    check("R8 example code word", int'(capVal), 7'b1000101);
    check("R8 example length", capCnt, NLEN);

    // R2 R3 R4 R5 R6: sweep all messages with several stall patterns
    for (int g = 0; g < 4; g++) begin
      for (int m = 0; m < 16; m++) begin
        doClear();
        sendMsg(4'(m), (g == 0) ? 0 : (g == 1) ? 15 : (g == 2) ? 5 : m);
        check("R2 R3 product value", int'(capVal), int'(clmul(4'(m))));
        check("R4 R6 code bit count", capCnt, NLEN);
        check("R5 single done", doneCnt, 1);
        check("R5 done on last bit", doneAt, NLEN);
      end
    end

    // R3: explicit stall cycle
    doClear();
    dataValid = 1'b1; dataIn = 1'b1; tick();
    dataValid = 1'b0; tick();
    @(negedge clk);
    check("R3 no code bit after stall", int'(codeValid), 0);

    // R7: abort mid-message then encode the example
    doClear();
    dataValid = 1'b1; dataIn = 1'b1; tick(); tick(); tick();
    doClear();
    @(negedge clk);
    check("R7 quiet after clear", int'(codeValid), 0);
    sendMsg(4'b1011, 2);
    check("R7 clean code word after abort", int'(capVal), 7'b1000101);
    check("R7 length after abort", capCnt, NLEN);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule